// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for the instruction sitting in the execute stage of an in-order pipeline, where each of its two source operands must come from. A value read from the register file during decode can be stale when an older instruction that writes the same register has not yet committed. Such a producer is at most two instructions ahead of the consumer. It is therefore still held in either the execute/memory pipeline register (one instruction ahead) or the memory/writeback pipeline register (two instructions ahead). The block compares both source register numbers against the destination numbers held in those two registers and emits a two-bit source code for each operand. It also steers the matching data through operand multiplexers.

When both in-flight producers write the same register, the younger one, in the execute/memory register, always wins. A writeback producer that is a load supplies its loaded memory word rather than its ALU result. The second operand can be replaced by an immediate. The store-data path still receives the bypassed value of the second source register. By default the outputs are registered, so the selects and the multiplexed data are observed together one clock after the inputs are presented.

Top module: `fwd_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output (both select codes, both operands and the store data) reads zero.
- R2: A source register that matches no enabled producer gets select code 2'b00, and its operand is the register-file value.
- R3: A source register equal to the execute/memory destination, with that register's write flag set, gets select code 2'b10, and its operand is the execute/memory result.
- R4: A source register that matches only the memory/writeback destination, with that register's write flag set, gets select code 2'b01, and its operand is the writeback value.
- R5: When both producers write the source register, the execute/memory producer (the younger one) is selected with code 2'b10.
- R6: A producer whose write flag is clear is ignored even when its destination matches. Selection then falls to the other producer or to the register file.
- R7: Register 31 is never bypassed. A source of 31 always gets code 2'b00, even when an enabled producer names 31 as its destination.
- R8: When the memory/writeback producer is a load (load flag high), the value it forwards is the loaded data word and not its ALU result.
- R9: With the immediate flag high, operand B is the immediate and select code B still reports the bypass choice for the second source register. The store-data output carries the bypassed value of that register.
- R10: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_rs1 | input | 5 | First source register of the execute-stage instruction |
| ex_rs2 | input | 5 | Second source register of the execute-stage instruction |
| ex_rf_a | input | 64 | Register-file value read for the first source |
| ex_rf_b | input | 64 | Register-file value read for the second source |
| ex_imm | input | 64 | Immediate for operand B |
| ex_use_imm | input | 1 | Operand B takes the immediate |
| xm_wen | input | 1 | Execute/memory register write flag |
| xm_rd | input | 5 | Execute/memory destination register |
| xm_alu | input | 64 | Execute/memory ALU result |
| mw_wen | input | 1 | Memory/writeback register write flag |
| mw_rd | input | 5 | Memory/writeback destination register |
| mw_is_load | input | 1 | Memory/writeback producer is a load |
| mw_alu | input | 64 | Memory/writeback ALU result |
| mw_load_data | input | 64 | Memory/writeback loaded data |
| sel_a | output | 2 | Source code for operand A (00 file, 10 exec/mem, 01 mem/wb) |
| sel_b | output | 2 | Source code for the second source register |
| op_a | output | 64 | Operand A |
| op_b | output | 64 | Operand B (bypassed value or immediate) |
| store_data | output | 64 | Bypassed value of the second source register |

## Verification
On every clock the embedded properties check four things against the inputs of the previous cycle: the younger producer wins a double match, a 01 code only appears with a real writeback match, register 31 never leaves the file path, and a load producer hands over its memory word. They also check that the immediate overrides operand B and that no code ever reads 2'b11. The bench's scenarios cover what those properties leave out. They confirm the zero outputs during reset and that a disabled producer is skipped in favour of the other one. They confirm the store-data path after an immediate override and that inputs changed between edges leave the outputs untouched until the next edge.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   typedef enum logic [1:0] {
      SRC_RF  = 2'b00,
      SRC_WB  = 2'b01,
      SRC_MEM = 2'b10
   } fwd_src_e;

   localparam int unsigned NUM_OPS = 2;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
   parameter int unsigned RW           = 5,
   parameter int unsigned ZERO_REG     = 31,
   parameter bit          HAS_ZERO_REG = 1'b1
) (
   input  logic [RW-1:0] src,
   input  logic [RW-1:0] dst,
   input  logic          wen,
   output logic          hit
);

   logic same;
   assign same = (src == dst);

   generate
      if (HAS_ZERO_REG) begin : g_zr
         logic dst_zero;
         assign dst_zero = (dst == RW'(ZERO_REG));
         assign hit      = wen && same && !dst_zero;
      end else begin : g_nozr
         assign hit = wen && same;
      end
   endgenerate

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
   import fwd_pkg::*;
(
   input  logic     hit_mem,
   input  logic     hit_wb,
   output fwd_src_e sel
);

   always_comb begin
      if (hit_mem)     sel = SRC_MEM;
      else if (hit_wb) sel = SRC_WB;
      else             sel = SRC_RF;
   end

   always_comb begin
      if (hit_mem) assert (sel == SRC_MEM) else $error("assert_young_first_R5");
   end

endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
   import fwd_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  fwd_src_e        sel,
   input  logic [XLEN-1:0] rf_val,
   input  logic [XLEN-1:0] mem_val,
   input  logic [XLEN-1:0] wb_val,
   output logic [XLEN-1:0] out
);

   always_comb begin
      unique case (sel)
         SRC_MEM: out = mem_val;
         SRC_WB:  out = wb_val;
         default: out = rf_val;
      endcase
   end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned XLEN         = 64,
   parameter int unsigned NREG         = 32,
   parameter int unsigned ZERO_REG     = NREG - 1,
   parameter bit          HAS_ZERO_REG = 1'b1,
   parameter bit          OUT_REG      = 1'b1,
   localparam int unsigned RW          = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RW-1:0]   ex_rs1,
   input  logic [RW-1:0]   ex_rs2,
   input  logic [XLEN-1:0] ex_rf_a,
   input  logic [XLEN-1:0] ex_rf_b,
   input  logic [XLEN-1:0] ex_imm,
   input  logic            ex_use_imm,
   input  logic            xm_wen,
   input  logic [RW-1:0]   xm_rd,
   input  logic [XLEN-1:0] xm_alu,
   input  logic            mw_wen,
   input  logic [RW-1:0]   mw_rd,
   input  logic            mw_is_load,
   input  logic [XLEN-1:0] mw_alu,
   input  logic [XLEN-1:0] mw_load_data,
   output logic [1:0]      sel_a,
   output logic [1:0]      sel_b,
   output logic [XLEN-1:0] op_a,
   output logic [XLEN-1:0] op_b,
   output logic [XLEN-1:0] store_data
);

   generate
      if (NREG < 2) begin : g_bad_nreg
         $error("fwd_unit: NREG must be at least 2");
      end
      if (HAS_ZERO_REG && ZERO_REG >= NREG) begin : g_bad_zr
         $error("fwd_unit: ZERO_REG out of range");
      end
      if (XLEN < 1) begin : g_bad_xlen
         $error("fwd_unit: XLEN must be positive");
      end
   endgenerate

   // writeback value: loaded word for loads, ALU result otherwise
   logic [XLEN-1:0] wb_val;
   assign wb_val = mw_is_load ? mw_load_data : mw_alu;

   logic [RW-1:0]   src   [NUM_OPS];
   logic [XLEN-1:0] rfv   [NUM_OPS];
   fwd_src_e        sel_c [NUM_OPS];
   logic [XLEN-1:0] fwd_c [NUM_OPS];

   assign src[0] = ex_rs1;
   assign src[1] = ex_rs2;
   assign rfv[0] = ex_rf_a;
   assign rfv[1] = ex_rf_b;

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
         logic hm, hw;
         fwd_hit #(.RW(RW), .ZERO_REG(ZERO_REG), .HAS_ZERO_REG(HAS_ZERO_REG)) u_hit_mem (
            .src(src[g]), .dst(xm_rd), .wen(xm_wen), .hit(hm));
         fwd_hit #(.RW(RW), .ZERO_REG(ZERO_REG), .HAS_ZERO_REG(HAS_ZERO_REG)) u_hit_wb (
            .src(src[g]), .dst(mw_rd), .wen(mw_wen), .hit(hw));
         fwd_pick u_pick (.hit_mem(hm), .hit_wb(hw), .sel(sel_c[g]));
         fwd_opmux #(.XLEN(XLEN)) u_mux (
            .sel(sel_c[g]), .rf_val(rfv[g]), .mem_val(xm_alu), .wb_val(wb_val),
            .out(fwd_c[g]));
      end
   endgenerate

   logic [XLEN-1:0] opb_c;
   assign opb_c = ex_use_imm ? ex_imm : fwd_c[1];

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sel_a      <= 2'b00;
               sel_b      <= 2'b00;
               op_a       <= '0;
               op_b       <= '0;
               store_data <= '0;
            end else begin
               sel_a      <= sel_c[0];
               sel_b      <= sel_c[1];
               op_a       <= fwd_c[0];
               op_b       <= opb_c;
               store_data <= fwd_c[1];
            end
         end

         assert_mem_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(xm_wen && (xm_rd == ex_rs1) &&
               !(HAS_ZERO_REG && xm_rd == RW'(ZERO_REG)))
            |-> (sel_a == 2'b10 && op_a == $past(xm_alu)));

         assert_wb_real_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && sel_a == 2'b01 |-> $past(mw_wen && (mw_rd == ex_rs1)));

         assert_no_bypass_zr_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && HAS_ZERO_REG && $past(ex_rs2 == RW'(ZERO_REG))
            |-> (sel_b == 2'b00 && store_data == $past(ex_rf_b)));

         assert_load_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && sel_a == 2'b01 && $past(mw_is_load)
            |-> op_a == $past(mw_load_data));

         assert_imm_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(ex_use_imm) |-> op_b == $past(ex_imm));

         assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
            sel_a != 2'b11 && sel_b != 2'b11);
      end else begin : g_comb
         assign sel_a      = sel_c[0];
         assign sel_b      = sel_c[1];
         assign op_a       = fwd_c[0];
         assign op_b       = opb_c;
         assign store_data = fwd_c[1];
      end
   endgenerate

endmodule

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;

   localparam logic [63:0] RFA  = 64'h0000_AAAA_0000_0001;
   localparam logic [63:0] RFB  = 64'h0000_BBBB_0000_0002;
   localparam logic [63:0] IMM  = 64'h0000_0000_0000_1234;
   localparam logic [63:0] XALU = 64'hEEEE_0000_0000_0003;
   localparam logic [63:0] WALU = 64'hDDDD_0000_0000_0004;
   localparam logic [63:0] WLD  = 64'hCCCC_0000_0000_0005;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  ex_rs1 = '0, ex_rs2 = '0, xm_rd = '0, mw_rd = '0;
   logic [63:0] ex_rf_a = RFA, ex_rf_b = RFB, ex_imm = IMM;
   logic [63:0] xm_alu = XALU, mw_alu = WALU, mw_load_data = WLD;
   logic        ex_use_imm = 1'b0, xm_wen = 1'b0, mw_wen = 1'b0, mw_is_load = 1'b0;
   logic [1:0]  sel_a, sel_b;
   logic [63:0] op_a, op_b, store_data;

   always #2.5 clk = ~clk;

   fwd_unit dut (
      .clk(clk), .rst_n(rst_n), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
      .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b), .ex_imm(ex_imm), .ex_use_imm(ex_use_imm),
      .xm_wen(xm_wen), .xm_rd(xm_rd), .xm_alu(xm_alu),
      .mw_wen(mw_wen), .mw_rd(mw_rd), .mw_is_load(mw_is_load), .mw_alu(mw_alu),
      .mw_load_data(mw_load_data),
      .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b), .store_data(store_data));

   typedef struct {
      logic [1:0]  sa, sb;
      logic [63:0] a, b, sd;
      string       tag;
   } exp_t;

   exp_t q[$];
   int checks = 0, fails = 0;
   bit done = 1'b0;

   function automatic logic [63:0] pick_val(logic [1:0] s, logic [63:0] rf, logic ld);
      case (s)
         2'b10:   return XALU;
         2'b01:   return ld ? WLD : WALU;
         default: return rf;
      endcase
   endfunction

   task automatic drive(input logic [4:0] r1, input logic [4:0] r2,
                        input logic xw, input logic [4:0] xd,
                        input logic mwen, input logic [4:0] md, input logic ld,
                        input logic ui, input logic [1:0] esa, input logic [1:0] esb,
                        input string tag);
      exp_t e;
      @(negedge clk);
      ex_rs1 = r1; ex_rs2 = r2; xm_wen = xw; xm_rd = xd;
      mw_wen = mwen; mw_rd = md; mw_is_load = ld; ex_use_imm = ui;
      e.sa  = esa;
      e.sb  = esb;
      e.a   = pick_val(esa, RFA, ld);
      e.sd  = pick_val(esb, RFB, ld);
      e.b   = ui ? IMM : e.sd;
      e.tag = tag;
      q.push_back(e);
   endtask

   // monitor / scoreboard
   always @(posedge clk) begin
      #1;
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (sel_a !== e.sa || sel_b !== e.sb || op_a !== e.a || op_b !== e.b ||
             store_data !== e.sd) begin
            fails++;
            $display("FAIL %s: got sa=%b sb=%b a=%h b=%h sd=%h exp sa=%b sb=%b a=%h b=%h sd=%h",
                     e.tag, sel_a, sel_b, op_a, op_b, store_data,
                     e.sa, e.sb, e.a, e.b, e.sd);
         end
      end
   end

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 20000);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
   end

   initial begin
      // R1: outputs zero during reset, even with matching producers
      xm_wen = 1'b1; xm_rd = 5'd3; ex_rs1 = 5'd3; ex_use_imm = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (sel_a !== 2'b00 || sel_b !== 2'b00 || op_a !== '0 || op_b !== '0 ||
          store_data !== '0) begin
         fails++;
         $display("FAIL R1: got sa=%b a=%h b=%h exp zeros", sel_a, op_a, op_b);
      end
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      checks++;
      if (op_a !== '0 || sel_a !== 2'b00) begin
         fails++;
         $display("FAIL R1: got sa=%b a=%h after release exp zeros", sel_a, op_a);
      end

      drive(5'd1, 5'd2, 1, 5'd5, 1, 5'd6, 0, 0, 2'b00, 2'b00, "R2 no match");
      drive(5'd5, 5'd2, 1, 5'd5, 1, 5'd6, 0, 0, 2'b10, 2'b00, "R3 mem hit A");
      drive(5'd1, 5'd5, 1, 5'd5, 1, 5'd6, 0, 0, 2'b00, 2'b10, "R3 mem hit B");
      drive(5'd6, 5'd2, 1, 5'd5, 1, 5'd6, 0, 0, 2'b01, 2'b00, "R4 wb hit A");
      drive(5'd7, 5'd7, 1, 5'd7, 1, 5'd7, 0, 0, 2'b10, 2'b10, "R5 double match");
      drive(5'd7, 5'd7, 0, 5'd7, 1, 5'd7, 0, 0, 2'b01, 2'b01, "R6 mem disabled");
      drive(5'd7, 5'd7, 0, 5'd7, 0, 5'd7, 0, 0, 2'b00, 2'b00, "R6 both disabled");
      drive(5'd31, 5'd31, 1, 5'd31, 1, 5'd31, 0, 0, 2'b00, 2'b00, "R7 reg31");
      drive(5'd3, 5'd31, 1, 5'd31, 1, 5'd3, 0, 0, 2'b01, 2'b00, "R7 reg31 skipped");
      drive(5'd4, 5'd4, 1, 5'd9, 1, 5'd4, 1, 0, 2'b01, 2'b01, "R8 load word");
      drive(5'd4, 5'd2, 1, 5'd4, 1, 5'd4, 1, 0, 2'b10, 2'b00, "R8 R5 young over load");
      drive(5'd1, 5'd5, 1, 5'd5, 1, 5'd6, 0, 1, 2'b00, 2'b10, "R9 imm with mem hit");
      drive(5'd1, 5'd6, 1, 5'd5, 1, 5'd6, 1, 1, 2'b00, 2'b01, "R9 imm store from load");
      drive(5'd1, 5'd2, 1, 5'd5, 1, 5'd6, 0, 1, 2'b00, 2'b00, "R9 imm no hit");
      drive(5'd5, 5'd6, 1, 5'd5, 1, 5'd6, 0, 0, 2'b10, 2'b01, "R10 R3 R4 split");
      // R10: new inputs are set; outputs must still hold the previous item
      #1;
      checks++;
      if (sel_a !== 2'b00 || sel_b !== 2'b00 || op_b !== IMM) begin
         fails++;
         $display("FAIL R10: got sa=%b sb=%b b=%h before edge exp 00 00 %h",
                  sel_a, sel_b, op_b, IMM);
      end
      drive(5'd0, 5'd0, 1, 5'd0, 1, 5'd0, 0, 0, 2'b10, 2'b10, "R5 reg0 double");
      repeat (4) @(posedge clk);
      #2;
      finish_run();
   end

endmodule